// File: doc/BRIEF.md
# Page Write Buffer and Word-Address Counter

This block sits between the serial bus engine of an 8192-by-8 non-volatile memory and its storage array. It keeps the 13-bit word-address counter that the bus engine loads from the address bytes and advances as bytes move. Bytes received during a write transaction go into a 32-slot page buffer, and each slot has its own valid flag. When the STOP that closes the write arrives, the block starts a timed internal write cycle. During that cycle it commits only the slots that were actually received to the array, through a single-cycle synchronous write port.

Writes and reads advance the counter differently. A received data byte moves only the 5-bit offset inside the page, so the row stays fixed and the offset wraps within the page. A byte sent out on a read moves the full 13-bit counter, which wraps from the top of the array to address 0. The write cycle lasts a parameter number of clocks. While it runs, `busy_o` is high and every bus-side input is ignored. A hardware protect input, sampled at STOP, cancels the commit. The counter holds its value between transactions, and a current-address read uses it.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `rd_addr_o` is 0, `busy_o` is low and `mem_we_o` is low.
- R2: While not busy, a pulse on `addr_load_i` makes `rd_addr_o` equal `addr_i` after the next clock edge and discards any buffered bytes. `addr_load_i` has priority over `wr_byte_i`, and `wr_byte_i` has priority over `rd_adv_i`.
- R3: While not busy, each `wr_byte_i` stores `wr_data_i` in slot `rd_addr_o[4:0]` and adds one to bits [4:0] only, wrapping 31 to 0. Bits [12:5] do not change.
- R4: While not busy, each `rd_adv_i` adds one to the full 13-bit counter, wrapping 8191 to 0.
- R5: A `stop_i` with at least one buffered byte and `wp_i` low raises `busy_o` after that edge, and `busy_o` then stays high for exactly WR_CYCLES clocks.
- R6: In busy cycle k (k = 0 to 31, counted from the first busy cycle), `mem_we_o` is high exactly when slot k holds a received byte. At that time `mem_addr_o` is {row, k} and `mem_wdata_o` is the last byte received for slot k. Slots that were not received are never written.
- R7: If more than 32 bytes arrive in one transaction, later bytes replace earlier ones in the same slot, and each slot is written at most once per cycle.
- R8: A `stop_i` with `wp_i` high writes nothing, leaves `busy_o` low and discards the buffered bytes.
- R9: A `stop_i` with no buffered byte, such as after a dummy address-only write, leaves `busy_o` low and keeps the counter.
- R10: While `busy_o` is high, `addr_load_i`, `wr_byte_i`, `rd_adv_i` and `stop_i` have no effect. The counter holds, and no byte is added to the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Hardware write protect, sampled at STOP |
| addr_load_i | input | 1 | Load the counter from `addr_i` |
| addr_i | input | 13 | Word address from the bus engine |
| wr_byte_i | input | 1 | One data byte received in a write |
| wr_data_i | input | 8 | Received data byte |
| rd_adv_i | input | 1 | One read byte sent; advance the counter |
| stop_i | input | 1 | STOP condition seen on the bus |
| rd_addr_o | output | 13 | Current word address (read address) |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 13 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
Most wrong internal states appear at the ports within a few clocks. A bad offset increment or a row that moves shows up on `rd_addr_o` after the next edge. A stale or lost valid flag shows up as a missing or extra `mem_we_o` pulse in the first 32 busy cycles, and a wrong buffered byte shows up on `mem_wdata_o` in the same cycle. A busy timer of the wrong length shows up at the falling edge of `busy_o`. A behavioural model in the bench tracks the counter, the page contents and the busy window, and compares every output on every clock. Because of that, each discrepancy is caught in the first cycle it becomes visible.

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int PAGE_AW   = 5,
  parameter int WR_CYCLES = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_i,
  input  logic          addr_load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_byte_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_adv_i,
  input  logic          stop_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int ROW_W = AW - PAGE_AW;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  logic [AW-1:0]      cnt;
  logic [ROW_W-1:0]   row_q;
  logic [DW-1:0]      dbuf [PAGE];
  logic [PAGE-1:0]    vld;
  logic [TW-1:0]      tmr;
  logic [PAGE_AW:0]   idx;

  wire [PAGE_AW-1:0] slot   = cnt[PAGE_AW-1:0];
  wire [PAGE_AW-1:0] wslot  = idx[PAGE_AW-1:0];
  wire               accept = !busy_o;
  wire               start  = accept && stop_i && (|vld) && !wp_i;
  wire               take   = accept && wr_byte_i && !addr_load_i;

  assign busy_o      = (tmr != '0);
  assign rd_addr_o   = cnt;
  assign mem_we_o    = busy_o && !idx[PAGE_AW] && vld[wslot];
  assign mem_addr_o  = {row_q, wslot};
  assign mem_wdata_o = dbuf[wslot];

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (accept) begin
      if (addr_load_i)
        cnt <= addr_i;
      else if (wr_byte_i)
        cnt <= {cnt[AW-1:PAGE_AW], slot + 1'b1};
      else if (rd_adv_i)
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      dbuf[slot] <= wr_data_i;
      row_q      <= cnt[AW-1:PAGE_AW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      vld <= '0;
    else if (busy_o) begin
      if (mem_we_o)
        vld[wslot] <= 1'b0;
    end else if (stop_i) begin
      if (!start)
        vld <= '0;
    end else if (addr_load_i)
      vld <= '0;
    else if (wr_byte_i)
      vld[slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr <= '0;
      idx <= '0;
    end else if (start) begin
      tmr <= TW'(WR_CYCLES);
      idx <= '0;
    end else if (busy_o) begin
      tmr <= tmr - 1'b1;
      if (!idx[PAGE_AW])
        idx <= idx + 1'b1;
    end
  end

  a_r5_commit_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stop_i && !wp_i && (vld != '0)) |=> busy_o);

  a_r8_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stop_i && wp_i) |=> !busy_o);

  a_r9_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stop_i && (vld == '0)) |=> !busy_o);

  a_r10_counter_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(rd_addr_o));

  a_r3_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_byte_i && !addr_load_i) |=>
      rd_addr_o[AW-1:PAGE_AW] == $past(rd_addr_o[AW-1:PAGE_AW]));

  a_r4_top_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_adv_i && !addr_load_i && !wr_byte_i && (&rd_addr_o)) |=>
      rd_addr_o == '0);
endmodule

// File: tb/page_write_buffer_tb.sv
module page_write_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WRC        = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_i = 1'b0;
  logic        addr_load_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic        wr_byte_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        rd_adv_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [12:0] rd_addr_o;
  logic        busy_o;
  logic        mem_we_o;
  logic [12:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;

  page_write_buffer #(.AW(13), .DW(8), .PAGE_AW(5), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_i(wp_i),
    .addr_load_i(addr_load_i), .addr_i(addr_i),
    .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i),
    .rd_adv_i(rd_adv_i), .stop_i(stop_i),
    .rd_addr_o(rd_addr_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int n_we   = 0;

  int        m_cnt, m_left, m_age, p_row, c_row;
  bit [31:0] p_val, c_val;
  int        p_dat [32];
  int        c_dat [32];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_left = 0; m_age = 0; p_val = '0; c_val = '0;
      p_row = 0; c_row = 0;
    end else if (m_left > 0) begin
      m_left--;
      m_age++;
    end else begin
      if (stop_i) begin
        if (p_val != 0 && !wp_i) begin
          c_val = p_val; c_row = p_row;
          foreach (p_dat[i]) c_dat[i] = p_dat[i];
          m_left = WRC; m_age = 0;
        end
        p_val = '0;
      end
      if (addr_load_i) begin
        m_cnt = addr_i;
        p_val = '0;
      end else if (wr_byte_i) begin
        p_dat[m_cnt % 32] = wr_data_i;
        p_val[m_cnt % 32] = 1'b1;
        p_row = m_cnt / 32;
        m_cnt = (m_cnt / 32) * 32 + ((m_cnt % 32) + 1) % 32;
      end else if (rd_adv_i) begin
        m_cnt = (m_cnt + 1) % 8192;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_we;
      exp_we = (m_left > 0) && (m_age < 32) && c_val[m_age % 32];
      chk(rd_addr_o == 13'(m_cnt), "R2/R3/R4 counter", rd_addr_o, m_cnt);
      chk(busy_o == (m_left > 0), "R5 busy window", busy_o, m_left > 0);
      chk(mem_we_o == exp_we, "R6 write strobe", mem_we_o, exp_we);
      if (mem_we_o) n_we++;
      if (exp_we && mem_we_o) begin
        chk(mem_addr_o == 13'(c_row * 32 + m_age), "R6 write addr", mem_addr_o, c_row * 32 + m_age);
        chk(mem_wdata_o == 8'(c_dat[m_age]), "R6/R7 write data", mem_wdata_o, c_dat[m_age]);
      end
    end
  end

  task automatic step(input bit ld, input int a, input bit wb, input int d, input bit adv, input bit st);
    @(negedge clk);
    addr_load_i = ld; addr_i = 13'(a); wr_byte_i = wb; wr_data_i = 8'(d);
    rd_adv_i = adv; stop_i = st;
    @(negedge clk);
    addr_load_i = 0; wr_byte_i = 0; rd_adv_i = 0; stop_i = 0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_addr_o == 0 && !busy_o && !mem_we_o, "R1 reset state",
        {rd_addr_o, busy_o, mem_we_o}, 0);

    step(1, 13'h0123, 0, 0, 0, 0);
    chk(rd_addr_o == 13'h0123, "R2 load", rd_addr_o, 13'h0123);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 8'h10 + i, 0, 0);
    chk(rd_addr_o == 13'h0126, "R3 offset step", rd_addr_o, 13'h0126);
    base = n_we;
    step(0, 0, 0, 0, 0, 1);
    chk(busy_o == 1, "R5 busy rises", busy_o, 1);
    wait_idle();
    chk(n_we - base == 3, "R6 partial page", n_we - base, 3);

    step(1, 13'h1FFE, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 8'hA0 + i, 0, 0);
    chk(rd_addr_o == 13'h1FE3, "R3 page wrap keeps row", rd_addr_o, 13'h1FE3);
    base = n_we;
    step(0, 0, 0, 0, 0, 1);
    wait_idle();
    chk(n_we - base == 5, "R3 wrapped commit count", n_we - base, 5);

    step(1, 13'h0040, 0, 0, 0, 0);
    for (int i = 0; i < 34; i++) step(0, 0, 1, 8'h50 + i, 0, 0);
    chk(rd_addr_o == 13'h0042, "R7 overrun offset", rd_addr_o, 13'h0042);
    base = n_we;
    step(0, 0, 0, 0, 0, 1);
    wait_idle();
    chk(n_we - base == 32, "R7 one write per slot", n_we - base, 32);

    step(1, 13'h0200, 0, 0, 0, 0);
    step(0, 0, 1, 8'hEE, 0, 0);
    step(0, 0, 1, 8'hEF, 0, 0);
    wp_i = 1'b1;
    base = n_we;
    step(0, 0, 0, 0, 0, 1);
    chk(busy_o == 0, "R8 protect no busy", busy_o, 0);
    repeat (WRC) @(negedge clk);
    chk(n_we - base == 0, "R8 protect no write", n_we - base, 0);
    wp_i = 1'b0;
    step(0, 0, 0, 0, 0, 1);
    chk(busy_o == 0, "R8 buffer discarded", busy_o, 0);

    step(1, 13'h1FFF, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    chk(busy_o == 0, "R9 dummy write no busy", busy_o, 0);
    chk(rd_addr_o == 13'h1FFF, "R9 counter kept", rd_addr_o, 13'h1FFF);
    step(0, 0, 0, 0, 1, 0);
    chk(rd_addr_o == 0, "R4 top wrap", rd_addr_o, 0);

    step(1, 13'h0FFF, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0);
    chk(rd_addr_o == 13'h1002, "R4 crosses page", rd_addr_o, 13'h1002);

    step(1, 13'h0010, 0, 0, 0, 0);
    step(0, 0, 1, 8'h77, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 13'h0999, 0, 0, 0, 0);
    step(0, 0, 1, 8'h88, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    chk(busy_o == 1 && rd_addr_o == 13'h0011, "R10 inputs ignored",
        rd_addr_o, 13'h0011);
    wait_idle();
    base = n_we;
    step(0, 0, 0, 0, 0, 1);
    chk(busy_o == 0, "R10 no byte captured while busy", busy_o, 0);
    repeat (4) @(negedge clk);
    chk(n_we - base == 0, "R10 no stray write", n_we - base, 0);

    finish_run();
  end
endmodule